// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Protector

This block guards one 8-bit data word held in memory. On the write side it turns the data byte into a 13-bit codeword, with no clock in the path. That codeword holds a 4-bit Hamming check code and an overall even-parity bit. The Hamming part uses twelve positions. Every position whose index is a power of two holds a check bit. Each check bit is the even parity of all data positions whose index shares its bit.

On the read side a codeword read back from storage comes in together with a valid strobe. The block recomputes the check code and XORs it with the stored check bits. The result is a 4-bit syndrome, and a nonzero syndrome is the 1-based position of a flipped bit. The block also rechecks the overall parity. It then registers the repaired data byte and two status flags, which appear one clock after the strobe. A single flipped bit anywhere in the codeword is repaired. Two flipped bits are flagged as uncorrectable, and the data is then passed through as read.

Top module: `secded_guard`

## Requirements
- R1: `wr_code[p]` for p = 1..12 is the Hamming position p, and `wr_code[0]` is the overall parity bit. Data bits D1..D8 (D1 = `wr_data[0]`, D8 = `wr_data[7]`) sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. The check bits are set as follows: position 1 = D1^D2^D4^D5^D7, position 2 = D1^D3^D4^D6^D7, position 4 = D2^D3^D4^D8, and position 8 = D5^D6^D7^D8.
- R2: `wr_code[0]` is set so that the XOR of all 13 bits of `wr_code` is 0.
- R3: `out_valid` is high in exactly the cycles that follow a clock edge at which `rd_valid` was high.
- R4: For a codeword with no flipped bit, `data_out` equals the encoded byte, and both `corrected` and `uncorrectable` are 0.
- R5: If exactly one of the positions 1..12 is flipped, `data_out` equals the original byte, `corrected` = 1 and `uncorrectable` = 0. The syndrome (position8,4,2,1 checks) equals the flipped position. For example, a flip at position 6 gives syndrome 0110 and repairs D3.
- R6: If only `rd_code[0]` is flipped, `data_out` equals the original byte, `corrected` = 1 and `uncorrectable` = 0.
- R7: If exactly two bits are flipped (the syndrome is nonzero and the parity matches), `uncorrectable` = 1 and `corrected` = 0. In that case `data_out` is the data positions of `rd_code` taken without any change.
- R8: If the syndrome is 13, 14 or 15 and the overall parity mismatches, `uncorrectable` = 1, `corrected` = 0, and `data_out` is the data positions taken without any change.
- R9: A synchronous active-high `rst` clears `out_valid`, `corrected` and `uncorrectable`. Both flags are 0 whenever `out_valid` is 0.
- R10: `corrected` and `uncorrectable` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 8 | Data byte to encode |
| wr_code | output | 13 | Encoded codeword (combinational) |
| rd_valid | input | 1 | `rd_code` holds a word to decode |
| rd_code | input | 13 | Codeword read back from storage |
| out_valid | output | 1 | Decoded result valid (one clock after `rd_valid`) |
| data_out | output | 8 | Decoded, repaired data byte |
| corrected | output | 1 | A single-bit error was repaired |
| uncorrectable | output | 1 | An uncorrectable error was detected |

## Verification
The encoder is swept over all 256 bytes. This catches any wrong data-bit placement or a missing term in a check equation. The decoder receives the following patterns:
- clean words, which separate a false alarm from a quiet decode;
- every single-position flip of one byte, which shows that each syndrome value points at the right bit;
- a flip of the lone parity bit, which is the only correctable case with a zero syndrome;
- pairs of flips, including the pairs that involve the parity bit, which must not be "repaired";
- triple flips that produce syndromes 13 and 15, which must be refused even though the parity mismatches.

Random bytes carrying zero, one or two random flips are mixed in. Read strobes are spaced apart so that the result timing and the quiet flags between reads are observed.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 8;
    localparam int CHK_W  = 4;
    localparam int HAM_W  = DATA_W + CHK_W;
    localparam int CODE_W = HAM_W + 1;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CHK_W-1:0]  syn_t;

    typedef enum logic [1:0] {
        DEC_CLEAN,
        DEC_FIXED,
        DEC_PAR_ONLY,
        DEC_BAD
    } dec_kind_e;

    typedef struct packed {
        data_t data;
        logic  corrected;
        logic  uncorrectable;
    } dec_res_t;

    function automatic logic is_pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic data_t ham_extract(code_t w);
        data_t d;
        int    k;
        d = '0;
        k = 0;
        for (int p = 1; p <= HAM_W; p++) begin
            if (!is_pow2(p)) begin
                d[k] = w[p];
                k++;
            end
        end
        return d;
    endfunction

    function automatic syn_t ham_syndrome(code_t w);
        syn_t s;
        s = '0;
        for (int i = 0; i < CHK_W; i++) begin
            for (int p = 1; p <= HAM_W; p++) begin
                if (p[i]) s[i] = s[i] ^ w[p];
            end
        end
        return s;
    endfunction

    function automatic code_t ham_encode(data_t d);
        code_t w;
        int    k;
        logic  c;
        w = '0;
        k = 0;
        for (int p = 1; p <= HAM_W; p++) begin
            if (!is_pow2(p)) begin
                w[p] = d[k];
                k++;
            end
        end
        for (int i = 0; i < CHK_W; i++) begin
            c = 1'b0;
            for (int p = 1; p <= HAM_W; p++) begin
                if (p[i] && !is_pow2(p)) c = c ^ w[p];
            end
            w[1 << i] = c;
        end
        w[0] = ^w[HAM_W:1];
        return w;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
(
    input  data_t data_i,
    output code_t code_o
);

    assign code_o = ham_encode(data_i);

    // R2: the whole codeword has even parity
    always_comb begin
        if (!$isunknown(data_i)) begin
            a_r2_even_word: assert (^code_o == 1'b0);
        end
    end

endmodule

// File: rtl/secded_syn.sv
module secded_syn
    import secded_pkg::*;
(
    input  code_t code_i,
    output syn_t  syn_o,
    output logic  par_err_o
);

    assign syn_o     = ham_syndrome(code_i);
    assign par_err_o = ^code_i;

endmodule

// File: rtl/secded_fix.sv
module secded_fix
    import secded_pkg::*;
(
    input  code_t    code_i,
    input  syn_t     syn_i,
    input  logic     par_err_i,
    output dec_res_t res_o
);

    dec_kind_e kind;
    logic      in_range;
    code_t     flip_mask;

    assign in_range = (syn_i != '0) && (int'(syn_i) <= HAM_W);

    always_comb begin
        if (syn_i == '0) kind = par_err_i ? DEC_PAR_ONLY : DEC_CLEAN;
        else if (par_err_i && in_range) kind = DEC_FIXED;
        else kind = DEC_BAD;
    end

    assign flip_mask[0] = 1'b0;
    for (genvar p = 1; p <= HAM_W; p++) begin : g_mask
        assign flip_mask[p] = (kind == DEC_FIXED) && (syn_i == CHK_W'(p));
    end

    always_comb begin
        res_o.data          = ham_extract(code_i ^ flip_mask);
        res_o.corrected     = (kind == DEC_FIXED) || (kind == DEC_PAR_ONLY);
        res_o.uncorrectable = (kind == DEC_BAD);
    end

    // R8: a syndrome beyond the last position is never repaired
    always_comb begin
        if (!$isunknown(code_i) && (int'(syn_i) > HAM_W)) begin
            a_r8_no_fix_beyond: assert (flip_mask == '0 && res_o.uncorrectable);
        end
    end

endmodule

// File: rtl/secded_guard.sv
module secded_guard
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CODE_W-1:0] wr_code,
    input  logic              rd_valid,
    input  logic [CODE_W-1:0] rd_code,
    output logic              out_valid,
    output logic [DATA_W-1:0] data_out,
    output logic              corrected,
    output logic              uncorrectable
);

    syn_t     syn;
    logic     par_err;
    dec_res_t res;

    secded_enc u_enc (
        .data_i (wr_data),
        .code_o (wr_code)
    );

    secded_syn u_syn (
        .code_i    (rd_code),
        .syn_o     (syn),
        .par_err_o (par_err)
    );

    secded_fix u_fix (
        .code_i    (rd_code),
        .syn_i     (syn),
        .par_err_i (par_err),
        .res_o     (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            data_out      <= '0;
            corrected     <= 1'b0;
            uncorrectable <= 1'b0;
        end else begin
            out_valid     <= rd_valid;
            corrected     <= rd_valid && res.corrected;
            uncorrectable <= rd_valid && res.uncorrectable;
            if (rd_valid) data_out <= res.data;
        end
    end

    // R3: result strobe follows the read strobe by one clock
    a_r3_valid_rise: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> out_valid);
    a_r3_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> !out_valid);

    // R9: reset clears strobe and flags; flags only with a strobe
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !corrected && !uncorrectable));
    a_r9_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
        (corrected || uncorrectable) |-> out_valid);

    // R10: the two flags exclude each other
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({corrected, uncorrectable}));

endmodule

// File: tb/secded_guard_tb_top.sv
`timescale 1ns/1ps
module secded_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  wr_data = '0;
    logic [12:0] wr_code;
    logic        rd_valid = 1'b0;
    logic [12:0] rd_code = '0;
    logic        out_valid;
    logic [7:0]  data_out;
    logic        corrected;
    logic        uncorrectable;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    secded_guard dut_i (
        .clk           (clk),
        .rst           (rst),
        .wr_data       (wr_data),
        .wr_code       (wr_code),
        .rd_valid      (rd_valid),
        .rd_code       (rd_code),
        .out_valid     (out_valid),
        .data_out      (data_out),
        .corrected     (corrected),
        .uncorrectable (uncorrectable)
    );

    function automatic logic [12:0] ref_encode(logic [7:0] d);
        logic [12:0] w;
        w = '0;
        w[3] = d[0]; w[5] = d[1]; w[6] = d[2]; w[7] = d[3];
        w[9] = d[4]; w[10] = d[5]; w[11] = d[6]; w[12] = d[7];
        w[1] = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
        w[2] = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
        w[4] = d[1] ^ d[2] ^ d[3] ^ d[7];
        w[8] = d[4] ^ d[5] ^ d[6] ^ d[7];
        w[0] = ^w[12:1];
        return w;
    endfunction

    function automatic logic [7:0] ref_raw(logic [12:0] w);
        return {w[12], w[11], w[10], w[9], w[7], w[6], w[5], w[3]};
    endfunction

    // returns {data, corrected, uncorrectable}
    function automatic logic [9:0] ref_decode(logic [12:0] w);
        logic [12:0] e;
        logic [3:0]  s;
        logic        p;
        e = ref_encode(ref_raw(w));
        s = {e[8] ^ w[8], e[4] ^ w[4], e[2] ^ w[2], e[1] ^ w[1]};
        p = ^w;
        if (s == 0 && !p) return {ref_raw(w), 2'b00};
        if (s == 0 && p)  return {ref_raw(w), 2'b10};
        if (p && s <= 12) begin
            e = w;
            e[s] = ~e[s];
            return {ref_raw(e), 2'b10};
        end
        return {ref_raw(w), 2'b01};
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [12:0] code, input string req);
        logic [9:0] exp;
        exp = ref_decode(code);
        @(negedge clk);
        rd_code  = code;
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        check(out_valid === 1'b1, "R3", {15'd0, out_valid}, 16'd1);
        check({data_out, corrected, uncorrectable} === exp, req,
              {6'd0, data_out, corrected, uncorrectable}, {6'd0, exp});
        @(negedge clk);
        check({out_valid, corrected, uncorrectable} === 3'b000, "R9",
              {13'd0, out_valid, corrected, uncorrectable}, 16'd0);
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [12:0] c;
        int          a, b;
        void'($urandom(32'h5EC0DED1));
        rd_valid = 1'b1;
        repeat (3) @(negedge clk);
        check({out_valid, corrected, uncorrectable} === 3'b000, "R9 reset",
              {13'd0, out_valid, corrected, uncorrectable}, 16'd0);
        rd_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // R1 / R2: full encoder sweep
        for (int v = 0; v < 256; v++) begin
            wr_data = 8'(v);
            #1;
            check(wr_code === ref_encode(8'(v)), "R1", {3'd0, wr_code}, {3'd0, ref_encode(8'(v))});
            check(^wr_code === 1'b0, "R2", {15'd0, ^wr_code}, 16'd0);
        end

        // R4: clean words
        do_read(ref_encode(8'h39), "R4");
        do_read(ref_encode(8'h00), "R4");
        do_read(ref_encode(8'hFF), "R4");

        // R5: position 6 flip on the worked byte, then every position
        c = ref_encode(8'h39);
        c[6] = ~c[6];
        do_read(c, "R5 pos6");
        for (int p = 1; p <= 12; p++) begin
            c = ref_encode(8'hA5);
            c[p] = ~c[p];
            do_read(c, "R5");
        end

        // R6: parity bit alone
        c = ref_encode(8'h5A);
        c[0] = ~c[0];
        do_read(c, "R6");

        // R7: doubles, including the parity bit
        c = ref_encode(8'h39); c[3] = ~c[3]; c[10] = ~c[10];
        do_read(c, "R7");
        c = ref_encode(8'hC3); c[0] = ~c[0]; c[7] = ~c[7];
        do_read(c, "R7 par");

        // R8: syndromes 13 and 15 with odd flip count
        c = ref_encode(8'h66); c[1] = ~c[1]; c[4] = ~c[4]; c[8] = ~c[8];
        do_read(c, "R8 s13");
        c = ref_encode(8'h66); c[12] = ~c[12]; c[1] = ~c[1]; c[0] = ~c[0];
        do_read(c, "R8 s13 data");
        c = ref_encode(8'h81); c[1] = ~c[1]; c[2] = ~c[2]; c[4] = ~c[4];
        c[8] = ~c[8]; c[0] = ~c[0];
        do_read(c, "R8 s15");

        // random mix, R10 checked on every result
        for (int n = 0; n < 400; n++) begin
            d = 8'($urandom);
            c = ref_encode(d);
            a = int'($urandom % 13);
            b = int'($urandom % 13);
            case ($urandom % 3)
                1: c[a] = ~c[a];
                2: if (a != b) begin c[a] = ~c[a]; c[b] = ~c[b]; end
                default: ;
            endcase
            do_read(c, "R5/R7 rand");
            check(!(corrected && uncorrectable), "R10",
                  {14'd0, corrected, uncorrectable}, 16'd0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule